// File: doc/BRIEF.md
# UART Status Flag Register

This block is the status and flag logic of a UART peripheral. It sits between the transmit and receive shift-register logic and the CPU register bus. It keeps a byte-wide, read-only status register. Three of its bits are flags that the block maintains itself: transmit buffer empty, transmission complete and receive buffer full. The other five bits are line-condition inputs (idle, overrun, noise, framing error, parity error), which are registered as they arrive.

The empty and full flags are set by event strobes from the shift-register logic. Software clears them with a two-step access: first a status read that sees the flag at 1, which arms it, then the matching data-register access. The complete flag follows the empty flag and the transmitter activity. It drops as soon as a frame, preamble or break is queued, and it stays low until the shifter has been busy and has gone idle again. Each flag has an enable input. The enabled transmit flags drive a shared transmitter interrupt, and the receive flag drives its own receiver interrupt. Both interrupts are registered, level-sensitive and active high.

Top module: `uart_stat_flags`

## Requirements
- R1: The status byte is {tx_empty (bit 7), tx_done (bit 6), rx_full (bit 5), line_in[4:0] (bits 4..0)}. Bits 4..0 equal the value that `line_in` had at the previous rising clock edge.
- R2: While `rst` is high at a clock edge, the status byte becomes 0xC0 and both interrupt outputs become 0.
- R3: A write strobe on the status register (`stat_wr`) has no effect on any status bit.
- R4: One cycle after `tx_handoff` is high, tx_empty (bit 7) is 1.
- R5: tx_empty falls only on a `data_wr` that follows a `stat_rd` which saw tx_empty at 1. A `data_wr` without that armed read, or after a read that saw tx_empty at 0, leaves tx_empty unchanged. The clearing write also disarms the flag.
- R6: tx_done (bit 6) is 1 only while tx_empty is 1, `tx_busy` is 0 and no queued transmission is waiting.
- R7: One cycle after `tx_queue` is high, tx_done is 0. It stays 0 until `tx_busy` has been seen high and then low again.
- R8: One cycle after `rx_load` is high, rx_full (bit 5) is 1.
- R9: rx_full falls only on a `data_rd` that follows a `stat_rd` which saw rx_full at 1. An unarmed `data_rd` leaves it unchanged.
- R10: When a set strobe and an armed clearing access meet in the same cycle, the flag stays 1.
- R11: `irq_tx` equals, one cycle later, (tx_empty AND `ie_empty`) OR (tx_done AND `ie_done`).
- R12: `irq_rx` equals, one cycle later, rx_full AND `ie_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_handoff | input | 1 | Transmit buffer moved a character into the shifter |
| rx_load | input | 1 | Receive shifter moved a character into the buffer |
| tx_queue | input | 1 | Data, preamble or break queued for sending |
| tx_busy | input | 1 | Shifter is sending data, preamble or break |
| line_in | input | 5 | Idle, overrun, noise, framing, parity conditions (bits 4..0) |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe (ignored) |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ie_empty | input | 1 | Interrupt enable for tx_empty |
| ie_done | input | 1 | Interrupt enable for tx_done |
| ie_full | input | 1 | Interrupt enable for rx_full |
| status | output | 8 | Status byte |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rx | output | 1 | Receiver interrupt request |

## Verification
The clear sequence is tried in three forms. A data access with no status read before it shows that arming is needed at all. A status read taken while the flag was 0, followed by a set and then an access, shows that the arm records the value that was read. The full read-then-access form shows the clear itself, and a set event landing on that same clearing access shows which of the two wins. The transmit-complete flag is driven through a queue strobe, a few busy cycles and a return to idle, which shows the queued gap apart from the busy period. The interrupt enables are toggled one at a time against set and cleared flags, which shows the two interrupt lines and their one-cycle lag apart. Alternating line patterns, together with status writes, show the capture path and that the writes are ignored.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam int LINE_W = 5;
    localparam int STAT_W = 3 + LINE_W;

    typedef struct packed {
        logic              tx_empty;
        logic              tx_done;
        logic              rx_full;
        logic [LINE_W-1:0] line;
    } stat_byte_t;

    localparam stat_byte_t STAT_RESET = '{tx_empty: 1'b1, tx_done: 1'b1,
                                          rx_full: 1'b0, line: '0};

    typedef struct packed {
        logic set_ev;
        logic stat_rd;
        logic access;
    } flag_ctl_t;

    function automatic logic next_arm(input logic rd, input logic acc,
                                      input logic flag, input logic arm);
        if (rd)
            return flag;
        else if (acc)
            return 1'b0;
        return arm;
    endfunction

endpackage

// File: rtl/stat_clr_flag.sv
module stat_clr_flag
    import uart_stat_pkg::*;
#(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t ctl,
    output logic      flag_q,
    output logic      flag_n
);
    logic arm_q;

    always_comb begin
        if (ctl.set_ev)
            flag_n = 1'b1;
        else if (ctl.access && arm_q)
            flag_n = 1'b0;
        else
            flag_n = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= RESET_VAL;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_n;
            arm_q  <= next_arm(ctl.stat_rd, ctl.access, flag_q, arm_q);
        end
    end
endmodule

// File: rtl/stat_txc_track.sv
module stat_txc_track (
    input  logic clk,
    input  logic rst,
    input  logic empty_n,
    input  logic tx_queue,
    input  logic tx_busy,
    output logic done_q
);
    logic pend_q;
    logic pend_n;
    logic done_n;

    always_comb begin
        pend_n = tx_queue | (pend_q & ~tx_busy);
        done_n = empty_n & ~tx_busy & ~pend_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_q <= 1'b1;
        end else begin
            pend_q <= pend_n;
            done_q <= done_n;
        end
    end
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic empty_q,
    input  logic done_q,
    input  logic full_q,
    input  logic ie_empty,
    input  logic ie_done,
    input  logic ie_full,
    output logic irq_tx,
    output logic irq_rx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_tx <= 1'b0;
            irq_rx <= 1'b0;
        end else begin
            irq_tx <= (empty_q & ie_empty) | (done_q & ie_done);
            irq_rx <= full_q & ie_full;
        end
    end
endmodule

// File: rtl/uart_stat_flags.sv
module uart_stat_flags
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_handoff,
    input  logic              rx_load,
    input  logic              tx_queue,
    input  logic              tx_busy,
    input  logic [LINE_W-1:0] line_in,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              ie_full,
    output logic [STAT_W-1:0] status,
    output logic              irq_tx,
    output logic              irq_rx
);
    localparam int NFLAG = 2;

    flag_ctl_t         ctl     [NFLAG];
    logic [NFLAG-1:0]  flg_q;
    logic [NFLAG-1:0]  flg_n;
    logic              done_q;
    logic [LINE_W-1:0] line_q;
    stat_byte_t        sb;
    logic              wr_unused;

    assign wr_unused = stat_wr;

    assign ctl[0] = '{set_ev: tx_handoff, stat_rd: stat_rd, access: data_wr};
    assign ctl[1] = '{set_ev: rx_load,    stat_rd: stat_rd, access: data_rd};

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam logic RV = (i == 0) ? STAT_RESET.tx_empty : STAT_RESET.rx_full;
        stat_clr_flag #(.RESET_VAL(RV)) u_flag (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl[i]),
            .flag_q (flg_q[i]),
            .flag_n (flg_n[i])
        );
    end

    stat_txc_track u_txc (
        .clk      (clk),
        .rst      (rst),
        .empty_n  (flg_n[0]),
        .tx_queue (tx_queue),
        .tx_busy  (tx_busy),
        .done_q   (done_q)
    );

    stat_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .empty_q  (flg_q[0]),
        .done_q   (done_q),
        .full_q   (flg_q[1]),
        .ie_empty (ie_empty),
        .ie_done  (ie_done),
        .ie_full  (ie_full),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx)
    );

    always_ff @(posedge clk) begin
        if (rst)
            line_q <= STAT_RESET.line;
        else
            line_q <= line_in;
    end

    always_comb begin
        sb.tx_empty = flg_q[0];
        sb.tx_done  = done_q;
        sb.rx_full  = flg_q[1];
        sb.line     = line_q;
        status      = sb;
    end
endmodule

// File: rtl/uart_stat_flags_chk.sv
module uart_stat_flags_chk
    import uart_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_handoff,
    input logic              rx_load,
    input logic              tx_queue,
    input logic              tx_busy,
    input logic [LINE_W-1:0] line_in,
    input logic              stat_rd,
    input logic              data_rd,
    input logic              data_wr,
    input logic              ie_empty,
    input logic              ie_done,
    input logic              ie_full,
    input logic [STAT_W-1:0] status,
    input logic              irq_tx,
    input logic              irq_rx
);
    assert_line_capture_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> status[LINE_W-1:0] == $past(line_in));

    assert_empty_set_R4: assert property (@(posedge clk) disable iff (rst)
        tx_handoff |=> status[7]);

    assert_empty_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (status[7] && !data_wr) |=> status[7]);

    assert_done_needs_empty_R6: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> (status[7] && !tx_busy));

    assert_done_queue_R7: assert property (@(posedge clk) disable iff (rst)
        tx_queue |=> !status[6]);

    assert_full_set_R8: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> status[5]);

    assert_full_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !data_rd) |=> status[5]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_load && data_rd && stat_rd) |=> status[5]);

    assert_irq_tx_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_tx == $past((status[7] & ie_empty) | (status[6] & ie_done)));

    assert_irq_rx_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_rx == $past(status[5] & ie_full));
endmodule

bind uart_stat_flags uart_stat_flags_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_handoff (tx_handoff),
    .rx_load    (rx_load),
    .tx_queue   (tx_queue),
    .tx_busy    (tx_busy),
    .line_in    (line_in),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .data_wr    (data_wr),
    .ie_empty   (ie_empty),
    .ie_done    (ie_done),
    .ie_full    (ie_full),
    .status     (status),
    .irq_tx     (irq_tx),
    .irq_rx     (irq_rx)
);

// File: tb/sim_uart_stat_flags.sv
module sim_uart_stat_flags;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      tag;
        logic [7:0] st;
        logic       itx;
        logic       irx;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_handoff = 0, rx_load = 0, tx_queue = 0, tx_busy = 0;
    logic [4:0] line_in = '0;
    logic       stat_rd = 0, stat_wr = 0, data_rd = 0, data_wr = 0;
    logic       ie_empty = 0, ie_done = 0, ie_full = 0;
    logic [7:0] status;
    logic       irq_tx, irq_rx;

    int n_cmp = 0;
    int n_bad = 0;
    exp_t sbq[$];

    // requirement model state
    logic m_e, m_d, m_f, a_e, a_f, m_p, m_itx, m_irx;
    logic [4:0] m_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_stat_flags u0 (
        .clk(clk), .rst(rst), .tx_handoff(tx_handoff), .rx_load(rx_load),
        .tx_queue(tx_queue), .tx_busy(tx_busy), .line_in(line_in),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .data_rd(data_rd), .data_wr(data_wr),
        .ie_empty(ie_empty), .ie_done(ie_done), .ie_full(ie_full),
        .status(status), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic compare(input string tag, input logic [7:0] st,
                           input logic itx, input logic irx);
        n_cmp++;
        if (status !== st || irq_tx !== itx || irq_rx !== irx) begin
            n_bad++;
            $display("FAIL %s: status=%02h irq_tx=%0b irq_rx=%0b expected status=%02h irq_tx=%0b irq_rx=%0b",
                     tag, status, irq_tx, irq_rx, st, itx, irx);
        end
    endtask

    // driver: called at a falling edge; drives one cycle and queues the result
    task automatic step(input string tag, input logic srd, input logic swr,
                        input logic drd, input logic dwr, input logic hof,
                        input logic rld, input logic que, input logic bsy,
                        input logic [4:0] ln);
        logic ne, nd, nf, np;
        exp_t it;
        stat_rd = srd; stat_wr = swr; data_rd = drd; data_wr = dwr;
        tx_handoff = hof; rx_load = rld; tx_queue = que; tx_busy = bsy;
        line_in = ln;
        ne = hof ? 1'b1 : ((dwr && a_e) ? 1'b0 : m_e);
        nf = rld ? 1'b1 : ((drd && a_f) ? 1'b0 : m_f);
        np = que | (m_p & ~bsy);
        nd = ne & ~bsy & ~np;
        m_itx = (m_e & ie_empty) | (m_d & ie_done);
        m_irx = m_f & ie_full;
        a_e = srd ? m_e : (dwr ? 1'b0 : a_e);
        a_f = srd ? m_f : (drd ? 1'b0 : a_f);
        m_e = ne; m_d = nd; m_f = nf; m_p = np; m_line = ln;
        it.tag = tag;
        it.st  = {m_e, m_d, m_f, m_line};
        it.itx = m_itx;
        it.irx = m_irx;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++)
            step(tag, 0, 0, 0, 0, 0, 0, 0, 0, m_line);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0) begin
                exp_t it;
                it = sbq.pop_front();
                compare(it.tag, it.st, it.itx, it.irx);
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_e = 1; m_d = 1; m_f = 0; a_e = 0; a_f = 0; m_p = 0;
        m_itx = 0; m_irx = 0; m_line = '0;
        compare("R2 reset value", 8'hC0, 1'b0, 1'b0);

        // R1: line capture with several patterns
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 5'h15);
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 5'h0A);
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 5'h1F);
        step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 5'h00);

        // R3: status writes ignored
        step("R3", 0, 1, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R3", 0, 1, 0, 0, 0, 0, 0, 0, 5'h00);
        idle("R3", 1);

        // R5: unarmed write does not clear
        step("R5 unarmed write", 0, 0, 0, 1, 0, 0, 0, 0, 5'h00);
        // R5: armed sequence clears tx_empty; R6 tx_done follows
        step("R5 status read", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R5 armed write", 0, 0, 0, 1, 0, 0, 0, 0, 5'h00);
        idle("R6 empty low", 2);
        // R5: read while 0 leaves unarmed
        step("R5 read at zero", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R4 handoff", 0, 0, 0, 0, 1, 0, 0, 0, 5'h00);
        step("R5 write after zero read", 0, 0, 0, 1, 0, 0, 0, 0, 5'h00);

        // R7: queue, busy, back to idle
        step("R7 queue", 0, 0, 0, 0, 0, 0, 1, 0, 5'h03);
        step("R7 gap", 0, 0, 0, 0, 0, 0, 0, 0, 5'h03);
        step("R7 busy", 0, 0, 0, 0, 0, 0, 0, 1, 5'h03);
        step("R7 busy", 0, 0, 0, 0, 0, 0, 0, 1, 5'h03);
        step("R6 busy", 0, 0, 0, 0, 0, 0, 0, 1, 5'h03);
        idle("R7 idle", 2);

        // R8 / R9
        step("R8 rx load", 0, 0, 0, 0, 0, 1, 0, 0, 5'h00);
        step("R9 unarmed read", 0, 0, 1, 0, 0, 0, 0, 0, 5'h00);
        step("R9 status read", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R9 armed read", 0, 0, 1, 0, 0, 0, 0, 0, 5'h00);
        idle("R9", 1);

        // R10: set collides with armed clear
        step("R10 load", 0, 0, 0, 0, 0, 1, 0, 0, 5'h00);
        step("R10 status read", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R10 collide rx", 0, 0, 1, 0, 0, 1, 0, 0, 5'h00);
        step("R10 status read tx", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R10 collide tx", 0, 0, 0, 1, 1, 0, 0, 0, 5'h00);
        idle("R10", 1);

        // R11 / R12: enables toggled one at a time
        ie_full = 1;
        idle("R12 enable", 2);
        ie_full = 0;
        idle("R12 disable", 2);
        ie_empty = 1;
        idle("R11 empty enable", 2);
        ie_empty = 0; ie_done = 1;
        idle("R11 done enable", 2);
        step("R11 queue drops done", 0, 0, 0, 0, 0, 0, 1, 0, 5'h00);
        step("R11 busy", 0, 0, 0, 0, 0, 0, 0, 1, 5'h00);
        idle("R11 done back", 3);
        ie_done = 0; ie_full = 1;
        step("R12 status read", 1, 0, 0, 0, 0, 0, 0, 0, 5'h00);
        step("R12 clear", 0, 0, 1, 0, 0, 0, 0, 0, 5'h00);
        idle("R12 drop", 3);

        @(posedge clk);
        #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule